// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable stand-in for a 1 Kbit serial EEPROM with a three-wire interface. It can be the target of a controller under test, in simulation or on an FPGA. The pins are sampled with the system clock. The chip-select, serial-clock and data-in pins pass through a short synchroniser, and the model acts on each detected rising edge of the serial clock.

A command opens with a 1 bit. Any 0 bits before it are skipped. Next comes a two-bit opcode and then the address, both MSB first. When the opcode is `00`, the two upper address bits choose one of four extended commands.

A parameter picks the organisation:
- 16-bit words: 64 locations, 6-bit address.
- 8-bit bytes: 128 locations, 7-bit address.

Reads return the addressed location on the data-out pin. Writes and erases are committed when chip select falls after a complete command, and only while programming is unlocked. A commit starts a busy period of programmable length, measured in system clocks, during which the data-out pin is held low.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `dout` is 1, programming is locked, and every location reads as all ones.
- R2: In idle with chip select high, 0 bits on `din` before the first 1 bit are ignored. That first 1 bit is the start bit.
- R3: Opcode `10` is a read. On the clock edge of the last address bit, `dout` becomes 0 (a dummy bit). On each of the next DATA-width rising edges, `dout` gives the next data bit, MSB first.
- R4: Opcode `01` is a write. It takes DATA-width data bits, MSB first, after the address. The value is stored when chip select falls after the last data bit.
- R5: While programming is locked, write, erase, write-all and erase-all leave the array unchanged and start no busy period.
- R6: With opcode `00`, upper address bits `11` unlock programming and `00` lock it again.
- R7: Opcode `11` is an erase. It sets the addressed location to all ones.
- R8: With opcode `00`, upper address bits `01` write the following data word to every location, and `10` set every location to all ones.
- R9: After a committed program operation, `dout` stays low for BUSY_CYCLES system clocks and then returns to 1.
- R10: Dropping chip select before the header or the data of a write is complete aborts the command. Nothing is stored and no busy period starts.
- R11: Word organisation uses a 6-bit address and 16-bit data. Byte organisation uses a 7-bit address and 8-bit data.
- R12: A command issued while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; inputs are taken on its rising edge |
| din | input | 1 | Serial data into the model |
| dout | output | 1 | Serial data out; low while busy |

## Verification
The embedded assertions check these on every cycle:
- No array update happens while programming is locked.
- Each busy period starts right after a chip-select fall that commits an operation.
- No array update happens while busy.
- A read header always produces the dummy 0 on the last address bit.
- A low chip select always returns the decoder to idle.

Only the bench's directed scenarios can show:
- the data actually stored and returned for each opcode;
- that leading zeros are skipped;
- the exact length of the busy period;
- the aborted and ignored commands;
- that the byte organisation uses the longer address and the shorter data word.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int CAPACITY_BITS = 1024;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_t;

    typedef enum logic [1:0] {
        EXT_LOCK   = 2'b00,
        EXT_FILL   = 2'b01,
        EXT_WIPE   = 2'b10,
        EXT_UNLOCK = 2'b11
    } ext_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DATA,
        ST_ARMED,
        ST_READ,
        ST_DONE
    } state_t;

    typedef enum logic [1:0] {
        K_WRITE,
        K_ERASE,
        K_FILL,
        K_WIPE
    } kind_t;

    function automatic int data_bits(bit word_org);
        return word_org ? 16 : 8;
    endfunction

    function automatic int addr_bits(bit word_org);
        return $clog2(CAPACITY_BITS / data_bits(word_org));
    endfunction

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int DATA_W = 16,
    parameter int AW     = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              we_all,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R8: single and bulk updates never requested together
    assert_single_port_R8: assert property (@(posedge clk) disable iff (rst)
        !(we && we_all));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
    parameter bit WORD_ORG    = 1'b1,
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sck,
    input  logic din,
    output logic dout
);
    import mw_pkg::*;

    localparam int DATA_W = data_bits(WORD_ORG);
    localparam int ADDR_W = addr_bits(WORD_ORG);
    localparam int HDR_W  = 2 + ADDR_W;
    localparam int HCNT_W = $clog2(HDR_W);
    localparam int DCNT_W = $clog2(DATA_W + 1);
    localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

    // pin synchronisation and edge detection
    logic [2:0] pins_s;
    logic       cs_s, sck_s, din_s, sck_prev, sck_rise;

    mw_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs, sck, din}),
        .q   (pins_s)
    );

    assign {cs_s, sck_s, din_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_prev;

    // decoder state
    state_t              state;
    kind_t               kind_q;
    logic                wen_q;
    logic                dout_r;
    logic [HDR_W-1:0]    hdr_q;
    logic [HDR_W-1:0]    hdr_next;
    logic [HCNT_W-1:0]   hdr_cnt;
    logic [DATA_W-1:0]   dat_q;
    logic [DCNT_W-1:0]   dat_cnt;
    logic [ADDR_W-1:0]   addr_q;
    logic [BCNT_W-1:0]   busy_cnt;
    logic                busy;
    logic                commit, mem_we, mem_we_all;
    logic [DATA_W-1:0]   rd_data;
    op_t                 hdr_op;
    ext_t                hdr_ext;

    assign hdr_next = {hdr_q[HDR_W-2:0], din_s};
    assign hdr_op   = op_t'(hdr_next[HDR_W-1 -: 2]);
    assign hdr_ext  = ext_t'(hdr_next[ADDR_W-1 -: 2]);
    assign busy     = (busy_cnt != '0);

    assign commit     = (state == ST_ARMED) && !cs_s && wen_q;
    assign mem_we     = commit && (kind_q == K_WRITE || kind_q == K_ERASE);
    assign mem_we_all = commit && (kind_q == K_FILL  || kind_q == K_WIPE);

    mw_array #(.DATA_W(DATA_W), .AW(ADDR_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .we_all (mem_we_all),
        .waddr  (addr_q),
        .wdata  (dat_q),
        .raddr  (hdr_next[ADDR_W-1:0]),
        .rdata  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind_q  <= K_WRITE;
            wen_q   <= 1'b0;
            dout_r  <= 1'b1;
            hdr_q   <= '0;
            hdr_cnt <= '0;
            dat_q   <= '0;
            dat_cnt <= '0;
            addr_q  <= '0;
        end else if (!cs_s) begin
            state   <= ST_IDLE;
            dout_r  <= 1'b1;
            hdr_cnt <= '0;
            dat_cnt <= '0;
        end else if (sck_rise) begin
            case (state)
                ST_IDLE: begin
                    if (din_s && !busy) begin
                        state   <= ST_HEAD;
                        hdr_cnt <= '0;
                    end
                end
                ST_HEAD: begin
                    hdr_q <= hdr_next;
                    if (hdr_cnt == HCNT_W'(HDR_W - 1)) begin
                        addr_q  <= hdr_next[ADDR_W-1:0];
                        dat_cnt <= '0;
                        case (hdr_op)
                            OP_READ: begin
                                dat_q  <= rd_data;
                                dout_r <= 1'b0;
                                state  <= ST_READ;
                            end
                            OP_WRITE: begin
                                kind_q <= K_WRITE;
                                state  <= ST_DATA;
                            end
                            OP_ERASE: begin
                                kind_q <= K_ERASE;
                                dat_q  <= '1;
                                state  <= ST_ARMED;
                            end
                            default: begin
                                case (hdr_ext)
                                    EXT_LOCK: begin
                                        wen_q <= 1'b0;
                                        state <= ST_DONE;
                                    end
                                    EXT_UNLOCK: begin
                                        wen_q <= 1'b1;
                                        state <= ST_DONE;
                                    end
                                    EXT_FILL: begin
                                        kind_q <= K_FILL;
                                        state  <= ST_DATA;
                                    end
                                    default: begin
                                        kind_q <= K_WIPE;
                                        dat_q  <= '1;
                                        state  <= ST_ARMED;
                                    end
                                endcase
                            end
                        endcase
                    end else begin
                        hdr_cnt <= hdr_cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    dat_q <= {dat_q[DATA_W-2:0], din_s};
                    if (dat_cnt == DCNT_W'(DATA_W - 1)) state <= ST_ARMED;
                    else                                 dat_cnt <= dat_cnt + 1'b1;
                end
                ST_READ: begin
                    if (dat_cnt == DCNT_W'(DATA_W)) begin
                        dout_r <= 1'b1;
                        state  <= ST_DONE;
                    end else begin
                        dout_r  <= dat_q[DATA_W-1];
                        dat_q   <= {dat_q[DATA_W-2:0], 1'b0};
                        dat_cnt <= dat_cnt + 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // programming busy period
    always_ff @(posedge clk) begin
        if (rst)                  busy_cnt <= '0;
        else if (commit)          busy_cnt <= BCNT_W'(BUSY_CYCLES);
        else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
    end

    assign dout = busy ? 1'b0 : dout_r;

    assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> dout);

    assert_read_dummy_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && $past(state) == ST_HEAD) |-> !dout);

    assert_no_write_when_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_we_all) |-> wen_q);

    assert_busy_after_commit_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(state == ST_ARMED && !cs_s));

    assert_cs_low_aborts_R10: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> (state == ST_IDLE));

    assert_quiet_while_busy_R12: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(mem_we || mem_we_all));
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
    localparam int HALF   = 4;
    localparam int BUSY_N = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_w = 1'b0, cs_b = 1'b0;
    logic sck = 1'b0, din = 1'b0;
    logic dout_w, dout_b;
    logic bm = 1'b0;
    logic last_q;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    mw_eeprom #(.WORD_ORG(1'b1), .BUSY_CYCLES(BUSY_N)) u_dut (
        .clk(clk), .rst(rst), .cs(cs_w), .sck(sck), .din(din), .dout(dout_w));

    mw_eeprom #(.WORD_ORG(1'b0), .BUSY_CYCLES(BUSY_N)) u_dut_byte (
        .clk(clk), .rst(rst), .cs(cs_b), .sck(sck), .din(din), .dout(dout_b));

    function automatic int aw();
        return bm ? 7 : 6;
    endfunction

    function automatic int dw();
        return bm ? 8 : 16;
    endfunction

    function automatic logic q_pin();
        return bm ? dout_b : dout_w;
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cs(input logic v);
        if (bm) cs_b = v;
        else    cs_w = v;
    endtask

    task automatic send_bit(input logic b);
        din = b;
        sck = 1'b1;
        waitc(HALF);
        sck = 1'b0;
        waitc(HALF);
        last_q = q_pin();
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [6:0] addr);
        set_cs(1'b1);
        waitc(HALF);
        send_bit(1'b1);
        send_bit(op[1]);
        send_bit(op[0]);
        for (int i = aw() - 1; i >= 0; i--) send_bit(addr[i]);
    endtask

    task automatic end_cmd();
        set_cs(1'b0);
        waitc(6);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 3000; i++) begin
            if (q_pin() === 1'b1) break;
            @(negedge clk);
        end
    endtask

    task automatic ext_cmd(input logic [1:0] sub);
        send_cmd(2'b00, 7'(sub) << (aw() - 2));
        end_cmd();
    endtask

    task automatic do_read(input logic [6:0] addr, output logic [15:0] data, output logic dummy);
        send_cmd(2'b10, addr);
        dummy = last_q;
        data = '0;
        for (int i = 0; i < dw(); i++) begin
            send_bit(1'b0);
            data = {data[14:0], last_q};
        end
        end_cmd();
    endtask

    task automatic send_data(input logic [15:0] data);
        for (int i = dw() - 1; i >= 0; i--) send_bit(data[i]);
    endtask

    task automatic do_write(input logic [6:0] addr, input logic [15:0] data);
        send_cmd(2'b01, addr);
        send_data(data);
        end_cmd();
        wait_ready();
        waitc(4);
    endtask

    task automatic expect_read(input string req, input logic [6:0] addr, input logic [15:0] exp);
        logic [15:0] d;
        logic        z;
        do_read(addr, d, z);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R1 dout word", 16'(dout_w), 16'h1);
        check("R1 dout byte", 16'(dout_b), 16'h1);
        expect_read("R1 erased word", 7'd5, 16'hFFFF);
        do_write(7'd5, 16'h0000);
        expect_read("R1 locked after reset", 7'd5, 16'hFFFF);
    endtask

    task automatic t_read_write();
        logic [15:0] d;
        logic        z;
        ext_cmd(2'b11);
        do_write(7'd3, 16'h1234);
        do_read(7'd3, d, z);
        check("R3 dummy bit", 16'(z), 16'h0);
        check("R4 R6 write then read", d, 16'h1234);
        do_write(7'd63, 16'hA5C3);
        expect_read("R4 top address", 7'd63, 16'hA5C3);
        expect_read("R4 neighbour untouched", 7'd2, 16'hFFFF);
    endtask

    task automatic t_locked();
        ext_cmd(2'b00);
        do_write(7'd3, 16'hBEEF);
        expect_read("R5 R6 locked write", 7'd3, 16'h1234);
        send_cmd(2'b11, 7'd3);
        end_cmd();
        waitc(2);
        check("R5 no busy when locked", 16'(dout_w), 16'h1);
        expect_read("R5 locked erase", 7'd3, 16'h1234);
    endtask

    task automatic t_leading_zeros();
        set_cs(1'b1);
        waitc(HALF);
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        expect_read("R2 zeros before start", 7'd63, 16'hA5C3);
    endtask

    task automatic t_erase();
        ext_cmd(2'b11);
        send_cmd(2'b11, 7'd3);
        end_cmd();
        wait_ready();
        waitc(4);
        expect_read("R7 erase", 7'd3, 16'hFFFF);
        expect_read("R7 other kept", 7'd63, 16'hA5C3);
    endtask

    task automatic t_bulk();
        send_cmd(2'b00, 7'(2'b01) << 4);
        send_data(16'h5A5A);
        end_cmd();
        wait_ready();
        waitc(4);
        expect_read("R8 write all lo", 7'd0, 16'h5A5A);
        expect_read("R8 write all hi", 7'd40, 16'h5A5A);
        ext_cmd(2'b10);
        wait_ready();
        waitc(4);
        expect_read("R8 erase all", 7'd40, 16'hFFFF);
    endtask

    task automatic t_busy();
        send_cmd(2'b01, 7'd9);
        send_data(16'h0F0F);
        set_cs(1'b0);
        waitc(8);
        check("R9 busy early", 16'(dout_w), 16'h0);
        waitc(BUSY_N - 16);
        check("R9 busy late", 16'(dout_w), 16'h0);
        waitc(20);
        check("R9 ready again", 16'(dout_w), 16'h1);
        expect_read("R9 data stored", 7'd9, 16'h0F0F);
    endtask

    task automatic t_abort();
        send_bit(1'b0);
        set_cs(1'b1);
        waitc(HALF);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        end_cmd();
        expect_read("R10 after header abort", 7'd9, 16'h0F0F);
        send_cmd(2'b01, 7'd9);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        end_cmd();
        check("R10 no busy after abort", 16'(dout_w), 16'h1);
        expect_read("R10 data kept", 7'd9, 16'h0F0F);
    endtask

    task automatic t_busy_ignore();
        send_cmd(2'b01, 7'd7);
        send_data(16'h1111);
        set_cs(1'b0);
        waitc(6);
        send_cmd(2'b01, 7'd7);
        send_data(16'h2222);
        end_cmd();
        wait_ready();
        waitc(4);
        expect_read("R12 command during busy", 7'd7, 16'h1111);
    endtask

    task automatic t_byte();
        logic [15:0] d;
        logic        z;
        bm = 1'b1;
        ext_cmd(2'b11);
        do_write(7'd127, 16'h00C6);
        do_read(7'd127, d, z);
        check("R11 byte dummy", 16'(z), 16'h0);
        check("R11 byte data", d, 16'h00C6);
        expect_read("R11 byte neighbour", 7'd126, 16'h00FF);
        do_write(7'd0, 16'h003C);
        expect_read("R11 byte low addr", 7'd0, 16'h003C);
        bm = 1'b0;
    endtask

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(5);
        t_reset();
        t_read_write();
        t_locked();
        t_leading_zeros();
        t_erase();
        t_bulk();
        t_busy();
        t_abort();
        t_busy_ignore();
        t_byte();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule